// File: doc/BRIEF.md
# Registered Bidirectional Bus Transceiver

This block joins two 8-lane buses, called A and B, and can carry data across in either direction. Each direction has its own capture register, its own capture clock, a source select and an output enable. The data lanes do not invert. Each bus appears as three vectors rather than a tri-state wire: the level seen on the bus (input), the value the block would drive (output) and a per-lane drive enable. Logic outside the block merges these into the shared wire.

In each direction the driven value is either the live level on the opposite bus or the value held in that direction's register, as the select input chooses. A register loads the level on its source bus on every rising edge of its own clock, whatever the select and enable inputs are doing. The A-to-B enable is active high and the B-to-A enable is active low. Holding both at their inactive levels isolates the buses. With both directions enabled and both selects set to stored, the two held values cross at the same time. With both directions enabled and both selects set to live, each bus drives the other, so the pair holds its last level once every outside driver lets go. A synchronous active-high reset clears each register on the next rising edge of that register's clock.

Top module: `dual_reg_xcvr`

## Requirements
- R1: The A-to-B register loads `a_in` on every rising edge of `clk_ab`, whatever the values of `sel_ab`, `sel_ba`, `oe_ab` and `oe_ba_n`.
- R2: The B-to-A register loads `b_in` on every rising edge of `clk_ba`, whatever the select and enable inputs are.
- R3: Every bit of `b_oe` is 1 while `oe_ab` is 1, and every bit is 0 while `oe_ab` is 0.
- R4: Every bit of `a_oe` is 1 while `oe_ba_n` is 0, and every bit is 0 while `oe_ba_n` is 1.
- R5: While `oe_ab`=1 and `sel_ab`=0, `b_out` equals `a_in` in the same cycle, with no clock involved.
- R6: While `oe_ab`=1 and `sel_ab`=1, `b_out` equals the A-to-B register.
- R7: While `oe_ba_n`=0, `a_out` equals `b_in` when `sel_ba`=0 and equals the B-to-A register when `sel_ba`=1.
- R8: With `oe_ab`=1, `oe_ba_n`=0, `sel_ab`=1 and `sel_ba`=1, the block drives the A-to-B register onto B and the B-to-A register onto A at the same time.
- R9: With `oe_ab`=0 and `oe_ba_n`=1 both buses are undriven by the block, and both registers still load on their clocks.
- R10: With both directions enabled and both selects at 0, each bus keeps its last level after every outside driver releases it.
- R11: While A is driven onto B in live mode, a rising edge of `clk_ba` loads the A value into the B-to-A register. While B is driven onto A in live mode, a rising edge of `clk_ab` loads the B value into the A-to-B register.
- R12: While `rst`=1, a rising edge of a direction's clock clears that direction's register to 0. The other register is not affected.
- R13: A direction whose enable is inactive drives all zeros on its output vector.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| rst | input | 1 | Synchronous active-high reset of both registers |
| clk_ab | input | 1 | Capture clock of the A-to-B register |
| clk_ba | input | 1 | Capture clock of the B-to-A register |
| oe_ab | input | 1 | Drive enable onto B, active high |
| oe_ba_n | input | 1 | Drive enable onto A, active low |
| sel_ab | input | 1 | Source for B: 0 live A, 1 stored A |
| sel_ba | input | 1 | Source for A: 0 live B, 1 stored B |
| a_in | input | 8 | Level present on bus A |
| a_out | output | 8 | Value driven onto bus A |
| a_oe | output | 8 | Per-lane drive enable for bus A |
| b_in | input | 8 | Level present on bus B |
| b_out | output | 8 | Value driven onto bus B |
| b_oe | output | 8 | Per-lane drive enable for bus B |

## Verification
The checker samples on each direction's own clock edge. At every edge it confirms the register load, the polarity of each enable, the live and stored output selection, the zero output of a disabled side, and the simultaneous exchange. Some behaviours depend on the outside bus. These are the self-holding latch, one bus reaching both registers through the live path, and isolation. Reset acting per clock is in the same group. Only the bench's scenarios can show them, because the bench models the shared wires with outside drivers, a keeper and contention detection.

// File: rtl/xcvr_pkg.sv
package xcvr_pkg;
  typedef enum logic {
    SRC_LIVE   = 1'b0,
    SRC_STORED = 1'b1
  } xcvr_src_e;

  localparam int unsigned DIR_AB = 0;
  localparam int unsigned DIR_BA = 1;
  localparam int unsigned NUM_DIRS = 2;
endpackage

// File: rtl/xcvr_cap_reg.sv
module xcvr_cap_reg #(
  parameter int unsigned WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst) q <= '0;
    else     q <= d;
  end
endmodule

// File: rtl/xcvr_drive.sv
module xcvr_drive
  import xcvr_pkg::*;
#(
  parameter int unsigned WIDTH         = 8,
  parameter bit          OE_ACTIVE_LOW = 1'b0
) (
  input  logic             sel,
  input  logic             en_pin,
  input  logic [WIDTH-1:0] live,
  input  logic [WIDTH-1:0] stored,
  output logic [WIDTH-1:0] dout,
  output logic [WIDTH-1:0] doe
);
  logic      en;
  xcvr_src_e src;

  assign en  = OE_ACTIVE_LOW ? ~en_pin : en_pin;
  assign src = xcvr_src_e'(sel);

  for (genvar i = 0; i < WIDTH; i++) begin : g_lane
    always_comb begin
      doe[i] = en;
      if (!en)                   dout[i] = 1'b0;
      else if (src == SRC_LIVE)  dout[i] = live[i];
      else                       dout[i] = stored[i];
    end
  end
endmodule

// File: rtl/dual_reg_xcvr.sv
module dual_reg_xcvr
  import xcvr_pkg::*;
#(
  parameter int unsigned LANES = 8
) (
  input  logic             rst,
  input  logic             clk_ab,
  input  logic             clk_ba,
  input  logic             oe_ab,
  input  logic             oe_ba_n,
  input  logic             sel_ab,
  input  logic             sel_ba,
  input  logic [LANES-1:0] a_in,
  output logic [LANES-1:0] a_out,
  output logic [LANES-1:0] a_oe,
  input  logic [LANES-1:0] b_in,
  output logic [LANES-1:0] b_out,
  output logic [LANES-1:0] b_oe
);
  logic             dir_clk [NUM_DIRS];
  logic             dir_sel [NUM_DIRS];
  logic             dir_en  [NUM_DIRS];
  logic [LANES-1:0] dir_src [NUM_DIRS];
  logic [LANES-1:0] dir_q   [NUM_DIRS];
  logic [LANES-1:0] dir_out [NUM_DIRS];
  logic [LANES-1:0] dir_oe  [NUM_DIRS];
  logic [LANES-1:0] q_ab;
  logic [LANES-1:0] q_ba;

  assign dir_clk[DIR_AB] = clk_ab;
  assign dir_clk[DIR_BA] = clk_ba;
  assign dir_sel[DIR_AB] = sel_ab;
  assign dir_sel[DIR_BA] = sel_ba;
  assign dir_en[DIR_AB]  = oe_ab;
  assign dir_en[DIR_BA]  = oe_ba_n;
  assign dir_src[DIR_AB] = a_in;
  assign dir_src[DIR_BA] = b_in;

  for (genvar d = 0; d < NUM_DIRS; d++) begin : g_dir
    xcvr_cap_reg #(.WIDTH(LANES)) u_reg (
      .clk (dir_clk[d]),
      .rst (rst),
      .d   (dir_src[d]),
      .q   (dir_q[d])
    );

    xcvr_drive #(
      .WIDTH         (LANES),
      .OE_ACTIVE_LOW (d == DIR_BA)
    ) u_drive (
      .sel    (dir_sel[d]),
      .en_pin (dir_en[d]),
      .live   (dir_src[d]),
      .stored (dir_q[d]),
      .dout   (dir_out[d]),
      .doe    (dir_oe[d])
    );
  end

  assign q_ab  = dir_q[DIR_AB];
  assign q_ba  = dir_q[DIR_BA];
  assign b_out = dir_out[DIR_AB];
  assign b_oe  = dir_oe[DIR_AB];
  assign a_out = dir_out[DIR_BA];
  assign a_oe  = dir_oe[DIR_BA];
endmodule

// File: rtl/dual_reg_xcvr_chk.sv
module dual_reg_xcvr_chk #(
  parameter int unsigned LANES = 8
) (
  input logic             rst,
  input logic             clk_ab,
  input logic             clk_ba,
  input logic             oe_ab,
  input logic             oe_ba_n,
  input logic             sel_ab,
  input logic             sel_ba,
  input logic [LANES-1:0] a_in,
  input logic [LANES-1:0] a_out,
  input logic [LANES-1:0] a_oe,
  input logic [LANES-1:0] b_in,
  input logic [LANES-1:0] b_out,
  input logic [LANES-1:0] b_oe,
  input logic [LANES-1:0] q_ab,
  input logic [LANES-1:0] q_ba
);
  AST_AB_CAPTURE: assert property (@(posedge clk_ab) disable iff (rst)
    !rst |=> q_ab == $past(a_in)); // R1

  AST_BA_CAPTURE: assert property (@(posedge clk_ba) disable iff (rst)
    !rst |=> q_ba == $past(b_in)); // R2

  AST_B_ENABLE_ON: assert property (@(posedge clk_ab) disable iff (rst)
    oe_ab |-> (&b_oe)); // R3

  AST_B_ENABLE_OFF: assert property (@(posedge clk_ab) disable iff (rst)
    !oe_ab |-> (b_oe == '0)); // R3

  AST_A_ENABLE_ON: assert property (@(posedge clk_ba) disable iff (rst)
    !oe_ba_n |-> (&a_oe)); // R4

  AST_A_ENABLE_OFF: assert property (@(posedge clk_ba) disable iff (rst)
    oe_ba_n |-> (a_oe == '0)); // R4

  AST_B_LIVE: assert property (@(posedge clk_ab) disable iff (rst)
    (oe_ab && !sel_ab) |-> (b_out == a_in)); // R5

  AST_B_STORED: assert property (@(posedge clk_ab) disable iff (rst)
    (oe_ab && sel_ab) |-> (b_out == q_ab)); // R6

  AST_A_LIVE: assert property (@(posedge clk_ba) disable iff (rst)
    (!oe_ba_n && !sel_ba) |-> (a_out == b_in)); // R7

  AST_A_STORED: assert property (@(posedge clk_ba) disable iff (rst)
    (!oe_ba_n && sel_ba) |-> (a_out == q_ba)); // R7

  AST_EXCHANGE: assert property (@(posedge clk_ab) disable iff (rst)
    (oe_ab && !oe_ba_n && sel_ab && sel_ba) |-> (b_out == q_ab && a_out == q_ba)); // R8

  AST_B_QUIET: assert property (@(posedge clk_ab) disable iff (rst)
    !oe_ab |-> (b_out == '0)); // R13

  AST_A_QUIET: assert property (@(posedge clk_ba) disable iff (rst)
    oe_ba_n |-> (a_out == '0)); // R13
endmodule

bind dual_reg_xcvr dual_reg_xcvr_chk #(.LANES(LANES)) u_chk (
  .rst     (rst),
  .clk_ab  (clk_ab),
  .clk_ba  (clk_ba),
  .oe_ab   (oe_ab),
  .oe_ba_n (oe_ba_n),
  .sel_ab  (sel_ab),
  .sel_ba  (sel_ba),
  .a_in    (a_in),
  .a_out   (a_out),
  .a_oe    (a_oe),
  .b_in    (b_in),
  .b_out   (b_out),
  .b_oe    (b_oe),
  .q_ab    (q_ab),
  .q_ba    (q_ba)
);

// File: tb/dual_reg_xcvr_tb.sv
module dual_reg_xcvr_tb;
  localparam int unsigned LANES  = 8;
  localparam int unsigned PERIOD = 10;
  localparam int unsigned NROWS  = 10;

  typedef struct packed {
    logic             oe_ab;
    logic             oe_ba_n;
    logic             sel_ab;
    logic             sel_ba;
    logic             ext_a_en;
    logic [LANES-1:0] ext_a;
    logic             ext_b_en;
    logic [LANES-1:0] ext_b;
    logic             pulse_ab;
    logic             pulse_ba;
    logic [LANES-1:0] exp_a;
    logic [LANES-1:0] exp_b;
  } row_t;

  localparam row_t ROWS [NROWS] = '{
    // R9 isolation, R1 R2 capture from outside drivers
    '{1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 8'h3C, 1'b1, 8'hA5, 1'b1, 1'b1, 8'h3C, 8'hA5},
    // R8 stored exchange
    '{1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 8'h00, 1'b0, 8'h00, 1'b0, 1'b0, 8'hA5, 8'h3C},
    // R5 live A to B, R11 clk_ba loads A value
    '{1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 8'h5A, 1'b0, 8'h00, 1'b0, 1'b1, 8'h5A, 8'h5A},
    // R7 stored B to A shows R11 result
    '{1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 8'h00, 1'b1, 8'h11, 1'b0, 1'b0, 8'h5A, 8'h11},
    // R7 live B to A, R11 clk_ab loads B value
    '{1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00, 1'b1, 8'hC3, 1'b1, 1'b0, 8'hC3, 8'hC3},
    // R6 stored A to B
    '{1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 8'h0F, 1'b0, 8'h00, 1'b0, 1'b0, 8'h0F, 8'hC3},
    // R1 capture while stored value drives B
    '{1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 8'h0F, 1'b0, 8'h00, 1'b1, 1'b0, 8'h0F, 8'h0F},
    // R5 live A to B with new value
    '{1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 8'h99, 1'b0, 8'h00, 1'b0, 1'b0, 8'h99, 8'h99},
    // R10 both live, drivers released, buses hold
    '{1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00, 1'b0, 8'h00, 1'b0, 1'b0, 8'h99, 8'h99},
    // R10 latch still holds across both clocks
    '{1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00, 1'b0, 8'h00, 1'b1, 1'b1, 8'h99, 8'h99}
  };

  logic             rst, clk_ab, clk_ba, oe_ab, oe_ba_n, sel_ab, sel_ba;
  logic [LANES-1:0] a_bus, b_bus, a_out, a_oe, b_out, b_oe;
  logic             ext_a_en, ext_b_en;
  logic [LANES-1:0] ext_a, ext_b;
  int unsigned      checks, fails;
  bit               done;

  dual_reg_xcvr #(.LANES(LANES)) u_dut (
    .rst(rst), .clk_ab(clk_ab), .clk_ba(clk_ba),
    .oe_ab(oe_ab), .oe_ba_n(oe_ba_n), .sel_ab(sel_ab), .sel_ba(sel_ba),
    .a_in(a_bus), .a_out(a_out), .a_oe(a_oe),
    .b_in(b_bus), .b_out(b_out), .b_oe(b_oe)
  );

  task automatic check(input string req, input logic [LANES-1:0] got,
                       input logic [LANES-1:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  // Resolve both shared wires: outside driver, then block, else keeper.
  task automatic settle();
    logic [LANES-1:0] na, nb;
    for (int k = 0; k < 4; k++) begin
      na = ext_a_en ? ext_a : (a_oe[0] ? a_out : a_bus);
      nb = ext_b_en ? ext_b : (b_oe[0] ? b_out : b_bus);
      a_bus = na;
      b_bus = nb;
      #1;
    end
    if ((ext_a_en && a_oe[0]) || (ext_b_en && b_oe[0])) begin
      checks++;
      fails++;
      $display("FAIL contention: got 1 expected 0");
    end
  endtask

  task automatic pulse(input logic pa, input logic pb);
    clk_ab = pa;
    clk_ba = pb;
    #(PERIOD / 2);
    clk_ab = 1'b0;
    clk_ba = 1'b0;
    #(PERIOD / 2);
  endtask

  task automatic set_ctrl(input logic a, input logic bn, input logic sa, input logic sb);
    oe_ab = a; oe_ba_n = bn; sel_ab = sa; sel_ba = sb;
  endtask

  initial begin
    #(PERIOD * 20000);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    checks = 0; fails = 0; done = 0;
    clk_ab = 0; clk_ba = 0; rst = 1;
    a_bus = '0; b_bus = '0;
    ext_a_en = 0; ext_b_en = 0; ext_a = '0; ext_b = '0;
    set_ctrl(1'b0, 1'b1, 1'b0, 1'b0);
    #1;
    settle();
    pulse(1'b1, 1'b1);
    rst = 0;

    // R12 reset state seen through stored exchange
    set_ctrl(1'b1, 1'b0, 1'b1, 1'b1);
    settle();
    check("R12 reset A side", a_bus, 8'h00);
    check("R12 reset B side", b_bus, 8'h00);

    foreach (ROWS[i]) begin
      set_ctrl(ROWS[i].oe_ab, ROWS[i].oe_ba_n, ROWS[i].sel_ab, ROWS[i].sel_ba);
      ext_a_en = ROWS[i].ext_a_en; ext_a = ROWS[i].ext_a;
      ext_b_en = ROWS[i].ext_b_en; ext_b = ROWS[i].ext_b;
      settle();
      pulse(ROWS[i].pulse_ab, ROWS[i].pulse_ba);
      settle();
      check($sformatf("R8 R9 R10 R11 row %0d bus A", i), a_bus, ROWS[i].exp_a);
      check($sformatf("R5 R6 R7 R1 R2 row %0d bus B", i), b_bus, ROWS[i].exp_b);
    end

    // R3 R4 R13 enable polarity and quiet outputs
    ext_a_en = 1; ext_a = 8'h77; ext_b_en = 1; ext_b = 8'h66;
    set_ctrl(1'b0, 1'b1, 1'b1, 1'b1);
    settle();
    check("R3 b_oe off", b_oe, 8'h00);
    check("R4 a_oe off", a_oe, 8'h00);
    check("R13 b_out quiet", b_out, 8'h00);
    check("R13 a_out quiet", a_out, 8'h00);
    // R9 isolation: capture with both disabled, then show values
    pulse(1'b1, 1'b1);
    ext_a_en = 0; ext_b_en = 0;
    set_ctrl(1'b1, 1'b0, 1'b1, 1'b1);
    settle();
    check("R3 b_oe on", b_oe, 8'hFF);
    check("R4 a_oe on", a_oe, 8'hFF);
    check("R9 R2 isolated capture B", a_bus, 8'h66);
    check("R9 R1 isolated capture A", b_bus, 8'h77);

    // R12 reset on one clock clears only that register
    rst = 1;
    pulse(1'b1, 1'b0);
    rst = 0;
    settle();
    check("R12 A-to-B cleared", b_bus, 8'h00);
    check("R12 B-to-A kept", a_bus, 8'h66);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule